// File: doc/BRIEF.md
# Free-Running Composite Video Sync Generator

This block is a free-running timing source for a video display path. It counts system clocks into half-lines, half-lines into fields, and from that position drives an active-low composite sync, a horizontal sync and a vertical sync. It covers a 625-line standard (64 µs line) and a 525-line standard (63.6 µs line), each in interlaced or progressive field structure. Around every field change it places a vertical interval of half-line-rate equalizing pulses, then broad pulses, then equalizing pulses again, so the composite output can feed a monitor directly.

A field flag and a line number within the field are also output, so a display engine can align pixel fetches to the raster. All durations are parameters in clock cycles. Their defaults come from a clocks-per-100-ns parameter, so the generator can sit on any pixel or system clock. The two mode pins are plain control levels. They are sampled only when a new field begins. There is no data stream, so no handshake is involved.

Top module: `csg_top`

## Requirements
- R1: The line period is `P_LINE_CLKS` clocks in 625-line mode (`std_sel`=0) and `N_LINE_CLKS` clocks in 525-line mode (`std_sel`=1). Each line is made of two half-lines of half that length.
- R2: Outside the vertical interval, `csync_n` goes low for `*_SYNC_CLKS` clocks at the start of each line. It stays high for the rest of the line, including at mid-line.
- R3: A field's first 15 half-lines form the vertical interval. Half-lines 0–4 and 10–14 carry an equalizing pulse: `csync_n` is low for `*_EQ_CLKS` from the start of the half-line. Half-lines 5–9 carry a broad pulse: low for `*_BROAD_CLKS`.
- R4: With `interlace_en`=1, a field lasts 625 (or 525) half-lines, so successive fields start alternately at a line start and at mid-line. That gives 313/312 lines (or 263/262). With `interlace_en`=0, every field lasts 624 (or 524) half-lines, which is 312 (or 262) whole lines.
- R5: `hsync_n` is low for `*_HS_CLKS` clocks at every line start, including inside the vertical interval. It is never low at mid-line.
- R6: `vsync_n` is low for exactly the first two half-lines (one line period) of every field.
- R7: `field_id` is 0 for a field that begins at a line start and 1 for a field that begins at mid-line. It therefore toggles every field when interlaced, and stays 0 when progressive from reset.
- R8: `line_num` becomes 0 at the first line start of a field. It rises by one at each later line start and holds its value in between.
- R9: `std_sel` and `interlace_en` are sampled during reset and at each field start. Changes made at any other time have no effect on the outputs until the next field begins.
- R10: While `rst` is high, `csync_n`, `hsync_n` and `vsync_n` are 1 and `field_id` and `line_num` are 0. Outputs are registered. The first clock edge after reset release shows clock 0 of half-line 0 of a line-start field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel/system clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 1 | 0 = 625-line standard, 1 = 525-line standard |
| interlace_en | input | 1 | 1 = interlaced field structure, 0 = progressive |
| csync_n | output | 1 | Composite sync, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| field_id | output | 1 | Field parity (0 = starts at line start) |
| line_num | output | LINE_W (10) | Line number within the current field |

## Verification
Most faults in this block sit in a counter: the clock-in-half-line count, the half-line phase, or the half-line-in-field count. A slip in the clock count shifts every later `csync_n` and `hsync_n` edge within one line. A wrong phase bit moves line syncs to mid-line at once. A wrong field length shows only at the next field boundary, where `vsync_n`, `field_id` and the broad-pulse block land in the wrong half-line. For that reason the bench compares every output on every clock across whole fields in both standards and both field structures, and includes a mid-field mode change.

// File: rtl/csg_pkg.sv
package csg_pkg;
  // Section of the field a half-line belongs to
  typedef enum logic [1:0] {
    SEG_PRE_EQ  = 2'd0,
    SEG_BROAD   = 2'd1,
    SEG_POST_EQ = 2'd2,
    SEG_ACTIVE  = 2'd3
  } seg_e;

  // Mode latched at field start
  typedef struct packed {
    logic std525;
    logic interlace;
  } cfg_t;
endpackage

// File: rtl/csg_timebase.sv
module csg_timebase
  import csg_pkg::*;
#(
  parameter int HC_W    = 12,
  parameter int FH_W    = 10,
  parameter int P_HALF  = 3200,
  parameter int N_HALF  = 3180,
  parameter int P_LINES = 625,
  parameter int N_LINES = 525
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            std_sel,
  input  logic            interlace_en,
  output logic [HC_W-1:0] hc,
  output logic            hph,
  output logic [FH_W-1:0] fh,
  output cfg_t            cfg,
  output logic            fid,
  output logic [FH_W-1:0] lc
);
  logic [HC_W-1:0] half_last;
  logic [FH_W-1:0] lines_sel, field_len;
  logic            half_end, field_end;
  logic [FH_W-1:0] fh_next;

  always_comb begin
    half_last = cfg.std525 ? HC_W'(N_HALF - 1) : HC_W'(P_HALF - 1);
    lines_sel = cfg.std525 ? FH_W'(N_LINES) : FH_W'(P_LINES);
    field_len = lines_sel - (cfg.interlace ? FH_W'(0) : FH_W'(1));
    half_end  = (hc == half_last);
    field_end = half_end && (fh == field_len - FH_W'(1));
    fh_next   = field_end ? '0 : fh + FH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc  <= '0;
      hph <= 1'b0;
      fh  <= '0;
      cfg <= '{std525: std_sel, interlace: interlace_en};
      fid <= 1'b0;
      lc  <= '0;
    end else if (half_end) begin
      hc  <= '0;
      hph <= ~hph;
      fh  <= fh_next;
      if (field_end) begin
        cfg <= '{std525: std_sel, interlace: interlace_en};
        fid <= ~hph;
      end
      // entering a line-start half-line
      if (hph) lc <= (fh_next <= FH_W'(1)) ? '0 : lc + FH_W'(1);
    end else begin
      hc <= hc + HC_W'(1);
    end
  end

  a_r4_fh_in_field: assert property (@(posedge clk) disable iff (rst)
    fh < field_len);
  a_r7_fid_moves_at_field_start: assert property (@(posedge clk) disable iff (rst)
    (fid != $past(fid)) |-> (fh == '0 && hc == '0));
  a_r8_line_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    (lc != $past(lc)) |-> (lc == '0 || lc == FH_W'($past(lc) + FH_W'(1))));
  a_r9_cfg_only_at_field_start: assert property (@(posedge clk) disable iff (rst)
    (cfg != $past(cfg)) |-> (fh == '0 && hc == '0));
endmodule

// File: rtl/csg_shaper.sv
module csg_shaper
  import csg_pkg::*;
#(
  parameter int HC_W      = 12,
  parameter int FH_W      = 10,
  parameter int VI_PULSES = 5,
  parameter int P_SYNC    = 470,
  parameter int P_EQ      = 235,
  parameter int P_BROAD   = 2730,
  parameter int P_HS      = 200,
  parameter int N_SYNC    = 470,
  parameter int N_EQ      = 230,
  parameter int N_BROAD   = 2710,
  parameter int N_HS      = 200
) (
  input  logic [HC_W-1:0] hc,
  input  logic            hph,
  input  logic [FH_W-1:0] fh,
  input  logic            std525,
  output logic            cs_low,
  output logic            hs_low,
  output logic            vs_low
);
  seg_e seg;
  int   w_sync, w_eq, w_broad, w_hs, pos, half_idx;

  always_comb begin
    w_sync   = std525 ? N_SYNC  : P_SYNC;
    w_eq     = std525 ? N_EQ    : P_EQ;
    w_broad  = std525 ? N_BROAD : P_BROAD;
    w_hs     = std525 ? N_HS    : P_HS;
    pos      = int'(hc);
    half_idx = int'(fh);
    if (half_idx < VI_PULSES)          seg = SEG_PRE_EQ;
    else if (half_idx < 2 * VI_PULSES) seg = SEG_BROAD;
    else if (half_idx < 3 * VI_PULSES) seg = SEG_POST_EQ;
    else                               seg = SEG_ACTIVE;
    unique case (seg)
      SEG_PRE_EQ, SEG_POST_EQ: cs_low = pos < w_eq;
      SEG_BROAD:               cs_low = pos < w_broad;
      default:                 cs_low = !hph && (pos < w_sync);
    endcase
    hs_low = !hph && (pos < w_hs);
    vs_low = half_idx < 2;
  end
endmodule

// File: rtl/csg_top.sv
module csg_top
  import csg_pkg::*;
#(
  parameter int TPU           = 10,
  parameter int P_LINE_CLKS   = 640 * TPU,
  parameter int P_SYNC_CLKS   = 47 * TPU,
  parameter int P_EQ_CLKS     = (235 * TPU) / 10,
  parameter int P_BROAD_CLKS  = 273 * TPU,
  parameter int P_HS_CLKS     = 20 * TPU,
  parameter int N_LINE_CLKS   = 636 * TPU,
  parameter int N_SYNC_CLKS   = 47 * TPU,
  parameter int N_EQ_CLKS     = 23 * TPU,
  parameter int N_BROAD_CLKS  = 271 * TPU,
  parameter int N_HS_CLKS     = 20 * TPU,
  parameter int P_LINES       = 625,
  parameter int N_LINES       = 525,
  parameter int VI_PULSES     = 5,
  parameter int LINE_W        = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              std_sel,
  input  logic              interlace_en,
  output logic              csync_n,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              field_id,
  output logic [LINE_W-1:0] line_num
);
  localparam int P_HALF   = P_LINE_CLKS / 2;
  localparam int N_HALF   = N_LINE_CLKS / 2;
  localparam int MAX_HALF = (P_HALF > N_HALF) ? P_HALF : N_HALF;
  localparam int HC_W     = (MAX_HALF > 2) ? $clog2(MAX_HALF) : 1;

  logic [HC_W-1:0]   hc;
  logic              hph, fid, cs_low, hs_low, vs_low;
  logic [LINE_W-1:0] fh, lc;
  cfg_t              cfg;

  csg_timebase #(
    .HC_W(HC_W), .FH_W(LINE_W), .P_HALF(P_HALF), .N_HALF(N_HALF),
    .P_LINES(P_LINES), .N_LINES(N_LINES)
  ) u_tb (
    .clk(clk), .rst(rst), .std_sel(std_sel), .interlace_en(interlace_en),
    .hc(hc), .hph(hph), .fh(fh), .cfg(cfg), .fid(fid), .lc(lc)
  );

  csg_shaper #(
    .HC_W(HC_W), .FH_W(LINE_W), .VI_PULSES(VI_PULSES),
    .P_SYNC(P_SYNC_CLKS), .P_EQ(P_EQ_CLKS), .P_BROAD(P_BROAD_CLKS), .P_HS(P_HS_CLKS),
    .N_SYNC(N_SYNC_CLKS), .N_EQ(N_EQ_CLKS), .N_BROAD(N_BROAD_CLKS), .N_HS(N_HS_CLKS)
  ) u_sh (
    .hc(hc), .hph(hph), .fh(fh), .std525(cfg.std525),
    .cs_low(cs_low), .hs_low(hs_low), .vs_low(vs_low)
  );

  // Registered outputs: one clock behind the position counters
  always_ff @(posedge clk) begin
    if (rst) begin
      csync_n  <= 1'b1;
      hsync_n  <= 1'b1;
      vsync_n  <= 1'b1;
      field_id <= 1'b0;
      line_num <= '0;
    end else begin
      csync_n  <= ~cs_low;
      hsync_n  <= ~hs_low;
      vsync_n  <= ~vs_low;
      field_id <= fid;
      line_num <= lc;
    end
  end

  // HS never outlasts the shortest composite pulse at a line start
  a_r5_hs_inside_cs: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !csync_n);
  a_r6_vs_only_early_in_field: assert property (@(posedge clk) disable iff (rst)
    !vs_low |-> (fh > LINE_W'(1)));
endmodule

// File: tb/sim_csg_top.sv
module sim_csg_top;
  localparam int LW = 10;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, std_sel = 1'b0, interlace_en = 1'b0;
  logic csync_n, hsync_n, vsync_n, field_id;
  logic [LW-1:0] line_num;

  csg_top #(
    .P_LINE_CLKS(64), .P_SYNC_CLKS(5), .P_EQ_CLKS(2), .P_BROAD_CLKS(27), .P_HS_CLKS(2),
    .N_LINE_CLKS(60), .N_SYNC_CLKS(5), .N_EQ_CLKS(2), .N_BROAD_CLKS(25), .N_HS_CLKS(2)
  ) u0 (
    .clk(clk), .rst(rst), .std_sel(std_sel), .interlace_en(interlace_en),
    .csync_n(csync_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .field_id(field_id), .line_num(line_num)
  );

  typedef struct {
    logic cs, hs, vs, fid;
    int   line;
    bit   in_vi;
  } exp_t;
  exp_t expq[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  // Driver: expected samples from the requirements, one per clock
  task automatic gen(input bit std, input bit [3:0] il_mask, input int nf, input int extra);
    int half = std ? 30 : 32;
    int lines = std ? 525 : 625;
    int w_sync = 5, w_eq = 2, w_hs = 2;
    int w_broad = std ? 25 : 27;
    bit ph = 1'b0;
    int ln = 0, cnt = 0;
    for (int f = 0; f <= nf; f++) begin
      bit il = il_mask[f];
      int len = il ? lines : lines - 1;  // R4
      bit fid = ph;                      // R7
      for (int h = 0; h < len; h++) begin
        bit ls = !ph;
        for (int c = 0; c < half; c++) begin
          exp_t e;
          if (ls && c == 0) ln = (h <= 1) ? 0 : ln + 1;  // R8
          if (h < 5 || (h >= 10 && h < 15)) e.cs = !(c < w_eq);  // R3
          else if (h < 15)                  e.cs = !(c < w_broad);
          else                              e.cs = !(ls && c < w_sync); // R2
          e.in_vi = h < 15;
          e.hs = !(ls && c < w_hs);  // R5
          e.vs = !(h < 2);           // R6
          e.fid = fid;
          e.line = ln;
          if (f == nf) begin
            if (cnt >= extra) return;
            cnt++;
          end
          expq.push_back(e);
        end
        ph = ~ph;
      end
    end
  endtask

  // Monitor: pops and compares one expected item per clock
  task automatic run(input string scen, input bit mid_switch);
    int n = expq.size();
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk);
      e = expq.pop_front();
      chk({scen, e.in_vi ? " R3 csync" : " R2 csync"}, csync_n, e.cs);
      chk({scen, " R1/R5 hsync"}, hsync_n, e.hs);
      chk({scen, " R6 vsync"}, vsync_n, e.vs);
      chk({scen, " R7 field_id"}, field_id, e.fid);
      chk({scen, " R8/R4 line_num"}, int'(line_num), e.line);
      if (mid_switch) begin
        // R9: mid-field changes must wait for the field boundary
        if (i == 1000) interlace_en = 1'b1;
        if (i == 2000) std_sel = 1'b0;
        if (i == 3000) std_sel = 1'b1;
      end
    end
  endtask

  task automatic start(input bit std, input bit il);
    rst = 1'b1;
    std_sel = std;
    interlace_en = il;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 csync reset", csync_n, 1);
    chk("R10 hsync reset", hsync_n, 1);
    chk("R10 vsync reset", vsync_n, 1);
    chk("R10 field reset", field_id, 0);
    chk("R10 line reset", int'(line_num), 0);
    rst = 1'b0;
  endtask

  initial begin
    // 625-line interlaced: fields A then B
    gen(1'b0, 4'b1111, 2, 40);
    start(1'b0, 1'b1);
    run("S1 625i", 1'b0);
    // 625-line progressive
    gen(1'b0, 4'b0000, 1, 40);
    start(1'b0, 1'b0);
    run("S2 625p", 1'b0);
    // 525-line interlaced
    gen(1'b1, 4'b1111, 2, 40);
    start(1'b1, 1'b1);
    run("S3 525i", 1'b0);
    // 525-line progressive, interlace and standard toggled mid-field (R9)
    gen(1'b1, 4'b1110, 3, 40);
    start(1'b1, 1'b0);
    run("S4 525 R9 switch", 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule